// File: doc/BRIEF.md
# NOR-emulation read front end

This block presents a byte-addressed, random-access read port to a host while the data actually lives in page-organised backing storage that can only be read a whole page at a time. Each host byte address is split into a logical block address (LBA) with a byte offset inside it, and into a page tag with a byte offset inside the page. A small on-chip page cache is organised as a ring of slots. Two ring indices bound the part of the ring that lookups may use: the access index marks the page the host is currently reading, and the fill index marks the page most recently pushed in by an external prefetcher.

A read whose page sits in a valid slot between the two indices (inclusive, in ring order) is a hit. The byte comes back one cycle after acceptance and the access index jumps to that slot. Pages between the old and new access index are not flushed. A read outside that window is a miss. The block raises a page-fetch request carrying the page's first LBA, collapses the window onto the slot after the access index, and writes the streamed page there. It returns the requested byte the cycle after the last fill beat. Outside a fetch, the same fill stream is a prefetch push into the slot after the fill index, and it is refused while the ring is full. The block drives both indices, a one-cycle miss pulse and a target-page report to the prefetcher.

The controller has three states. IDLE accepts a read: on a hit it goes to REPLY, on a miss it goes to FETCH. FETCH holds the fetch request and goes to REPLY on the last fill beat. REPLY returns the byte for one cycle and goes back to IDLE.

Top module: `norfe_read_front`

## Requirements
- R1: After reset, host_ready is 1, host_rvalid, fetch_req, miss_pulse and tgt_valid are 0, and ring_cur and ring_next are both 0. No slot is valid, so the first read misses.
- R2: Address split: the LBA of a byte is host_addr shifted right by log2(LBA_BYTES). The page tag is host_addr shifted right by log2(LBA_BYTES*PAGE_LBAS). On a miss, fetch_lba equals page tag times PAGE_LBAS, and tgt_lba equals the LBA of the read.
- R3: A read whose page is valid in a slot in the window from ring_cur to ring_next (inclusive, ring order) is a hit. host_rvalid is 1 with the byte the cycle after acceptance, no fetch is raised, ring_cur becomes that slot and ring_next is unchanged.
- R4: A page still stored in a slot outside the window (behind ring_cur) is not a hit, and the read misses.
- R5: On a miss, in the cycle after acceptance fetch_req is 1, miss_pulse is 1 for exactly that one cycle, and ring_cur and ring_next both equal (old ring_cur + 1) mod SLOTS.
- R6: During a fetch, fill beats carry the page bytes in offset order starting at 0, with fill_last on the final beat. The requested byte is returned with host_rvalid the cycle after the fill_last beat, and the page then hits.
- R7: Outside a fetch, a fill stream writes slot (ring_next + 1) mod SLOTS. On its fill_last beat ring_next advances by one, and the page can hit. Pages between ring_cur and ring_next stay readable when ring_cur moves forward.
- R8: While the ring is full ((ring_next + 1) mod SLOTS == ring_cur), prefetch fill beats are ignored: ring_next does not move and the page at ring_cur still reads back correctly.
- R9: When the same page is valid in several window slots, the one nearest to ring_cur in ring order wins, and ring_cur moves to it.
- R10: When the page at ring_cur was pushed with fill_branch set and an accepted read targets a different page, tgt_valid pulses for one cycle, the cycle after acceptance, with tgt_lba. Otherwise no pulse is given.
- R11: host_ready is 1 only in IDLE, so at most one read is outstanding, and each accepted read gives exactly one host_rvalid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host byte address |
| host_ready | output | 1 | Read can be accepted |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 8 | Read byte |
| fetch_req | output | 1 | On-demand page fetch in progress |
| fetch_lba | output | ADDR_W-log2(LBA_BYTES) | First LBA of the page to fetch |
| fill_valid | input | 1 | Page byte beat |
| fill_data | input | 8 | Page byte |
| fill_last | input | 1 | Final beat of a page |
| fill_tag | input | ADDR_W-log2(LBA_BYTES*PAGE_LBAS) | Page tag of a prefetch push |
| fill_branch | input | 1 | Page has several possible successors |
| ring_cur | output | log2(SLOTS) | Access index |
| ring_next | output | log2(SLOTS) | Fill index |
| miss_pulse | output | 1 | One-cycle miss indication |
| tgt_valid | output | 1 | Target page report after a branch page |
| tgt_lba | output | ADDR_W-log2(LBA_BYTES) | LBA of the target read |

## Verification
The bench aims at the window edge: it reads a page that is still stored but lies just behind ring_cur. A design that searched every slot would return a hit there instead of a miss. It fills the ring to full and pushes once more; a design without the full guard would overwrite the current page and return a wrong byte on the next read. It places a duplicate page in the window, where picking the farther copy shows up in ring_cur. It also checks that the miss pulse and target pulse last one cycle, carry the right LBA, and are missing when the read stays on the current page.

// File: rtl/norfe_pkg.sv
package norfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } fe_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/norfe_lookup.sv
module norfe_lookup #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2,
    parameter int PAGE_W = 7
) (
    input  logic [SLOT_W-1:0]             cur,
    input  logic [SLOT_W-1:0]             nxt,
    input  logic [SLOTS-1:0]              vld,
    input  logic [SLOTS-1:0][PAGE_W-1:0]  tags,
    input  logic [PAGE_W-1:0]             req_tag,
    output logic                          hit,
    output logic [SLOT_W-1:0]             slot
);
    int span;
    logic [SLOTS-1:0][SLOT_W-1:0] pos;
    logic [SLOTS-1:0]             match;

    // distance from access index to fill index in ring order
    always_comb span = (int'(nxt) - int'(cur) + SLOTS) % SLOTS;

    for (genvar i = 0; i < SLOTS; i++) begin : g_way
        localparam int OFS = i;
        assign pos[i]   = SLOT_W'((int'(cur) + OFS) % SLOTS);
        assign match[i] = (OFS <= span) && vld[pos[i]] && (tags[pos[i]] == req_tag);
    end

    // nearest slot to the access index wins
    always_comb begin
        hit  = 1'b0;
        slot = cur;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                slot = pos[i];
            end
        end
    end
endmodule

// File: rtl/norfe_store.sv
module norfe_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    q
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        q <= mem[raddr];
    end
endmodule

// File: rtl/norfe_read_front.sv
module norfe_read_front
    import norfe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LBA_BYTES = 512,
    parameter int PAGE_LBAS = 1,
    parameter int SLOTS     = 4,
    localparam int OFF_W    = $clog2(LBA_BYTES),
    localparam int POFF_W   = $clog2(LBA_BYTES * PAGE_LBAS),
    localparam int PAGE_W   = ADDR_W - POFF_W,
    localparam int LBA_W    = ADDR_W - OFF_W,
    localparam int SLOT_W   = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [7:0]        host_rdata,
    output logic              fetch_req,
    output logic [LBA_W-1:0]  fetch_lba,
    input  logic              fill_valid,
    input  logic [7:0]        fill_data,
    input  logic              fill_last,
    input  logic [PAGE_W-1:0] fill_tag,
    input  logic              fill_branch,
    output logic [SLOT_W-1:0] ring_cur,
    output logic [SLOT_W-1:0] ring_next,
    output logic              miss_pulse,
    output logic              tgt_valid,
    output logic [LBA_W-1:0]  tgt_lba
);
    localparam int LBA_SH = POFF_W - OFF_W;
    localparam int MEM_AW = SLOT_W + POFF_W;

    function automatic logic [SLOT_W-1:0] ring_inc(input logic [SLOT_W-1:0] s);
        return (int'(s) == SLOTS - 1) ? '0 : s + 1'b1;
    endfunction

    fe_state_e st_q, st_d;

    logic [SLOT_W-1:0]            cur_q, nxt_q;
    logic [SLOTS-1:0]             vld_q, br_q;
    logic [SLOTS-1:0][PAGE_W-1:0] tag_q;
    logic [POFF_W-1:0]            cnt_q, off_q;
    logic [PAGE_W-1:0]            rtag_q;
    logic                         from_fill_q;
    logic [7:0]                   cap_q;
    logic                         miss_q, tgt_q;
    logic [LBA_W-1:0]             tgt_lba_q, flba_q;

    logic [PAGE_W-1:0] req_tag;
    logic [POFF_W-1:0] req_off;
    logic              accept, lk_hit, ring_full, pf_beat, fx_beat, cur_on_branch;
    logic [SLOT_W-1:0] lk_slot, pf_slot, miss_slot, wr_slot;
    logic [7:0]        store_q;

    assign req_tag   = host_addr[ADDR_W-1:POFF_W];
    assign req_off   = host_addr[POFF_W-1:0];
    assign accept    = host_valid && (st_q == ST_IDLE);
    assign pf_slot   = ring_inc(nxt_q);
    assign miss_slot = ring_inc(cur_q);
    assign ring_full = (pf_slot == cur_q);
    assign fx_beat   = fill_valid && (st_q == ST_FETCH);
    assign pf_beat   = fill_valid && (st_q != ST_FETCH) && !ring_full;
    assign wr_slot   = fx_beat ? nxt_q : pf_slot;
    assign cur_on_branch = vld_q[cur_q] && br_q[cur_q] && (tag_q[cur_q] != req_tag);

    norfe_lookup #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .PAGE_W (PAGE_W)
    ) u_lookup (
        .cur     (cur_q),
        .nxt     (nxt_q),
        .vld     (vld_q),
        .tags    (tag_q),
        .req_tag (req_tag),
        .hit     (lk_hit),
        .slot    (lk_slot)
    );

    norfe_store #(
        .AW (MEM_AW)
    ) u_store (
        .clk   (clk),
        .we    (pf_beat || fx_beat),
        .waddr ({wr_slot, cnt_q}),
        .wdata (fill_data),
        .raddr ({lk_slot, req_off}),
        .q     (store_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = lk_hit ? ST_REPLY : ST_FETCH;
            ST_FETCH: if (fx_beat && fill_last) st_d = ST_REPLY;
            ST_REPLY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ready  = 1'b0;
        host_rvalid = 1'b0;
        fetch_req   = 1'b0;
        host_rdata  = '0;
        unique case (st_q)
            ST_IDLE:  host_ready = 1'b1;
            ST_FETCH: fetch_req  = 1'b1;
            ST_REPLY: begin
                host_rvalid = 1'b1;
                host_rdata  = from_fill_q ? cap_q : store_q;
            end
            default: ;
        endcase
    end

    assign ring_cur   = cur_q;
    assign ring_next  = nxt_q;
    assign miss_pulse = miss_q;
    assign tgt_valid  = tgt_q;
    assign tgt_lba    = tgt_lba_q;
    assign fetch_lba  = flba_q;

    // ring, tags and fill datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            nxt_q       <= '0;
            vld_q       <= '0;
            br_q        <= '0;
            tag_q       <= '0;
            cnt_q       <= '0;
            off_q       <= '0;
            rtag_q      <= '0;
            from_fill_q <= 1'b0;
            cap_q       <= '0;
            miss_q      <= 1'b0;
            tgt_q       <= 1'b0;
            tgt_lba_q   <= '0;
            flba_q      <= '0;
        end else begin
            miss_q <= 1'b0;
            tgt_q  <= 1'b0;
            if (pf_beat || fx_beat) cnt_q <= cnt_q + 1'b1;
            if (fx_beat && (cnt_q == off_q)) cap_q <= fill_data;
            if (pf_beat && fill_last) begin
                vld_q[pf_slot] <= 1'b1;
                tag_q[pf_slot] <= fill_tag;
                br_q[pf_slot]  <= fill_branch;
                nxt_q          <= pf_slot;
                cnt_q          <= '0;
            end
            if (fx_beat && fill_last) begin
                vld_q[nxt_q] <= 1'b1;
                tag_q[nxt_q] <= rtag_q;
                br_q[nxt_q]  <= fill_branch;
                cnt_q        <= '0;
            end
            if (accept) begin
                off_q     <= req_off;
                rtag_q    <= req_tag;
                tgt_q     <= cur_on_branch;
                tgt_lba_q <= host_addr[ADDR_W-1:OFF_W];
                if (lk_hit) begin
                    cur_q       <= lk_slot;
                    from_fill_q <= 1'b0;
                end else begin
                    cur_q            <= miss_slot;
                    nxt_q            <= miss_slot;
                    vld_q[miss_slot] <= 1'b0;
                    miss_q           <= 1'b1;
                    from_fill_q      <= 1'b1;
                    cnt_q            <= '0;
                    flba_q           <= LBA_W'(req_tag) << LBA_SH;
                end
            end
        end
    end
endmodule

// File: rtl/norfe_read_front_chk.sv
module norfe_read_front_chk #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic              fetch_req,
    input logic              fill_valid,
    input logic              fill_last,
    input logic              miss_pulse,
    input logic              tgt_valid,
    input logic [SLOT_W-1:0] ring_cur,
    input logic [SLOT_W-1:0] ring_next,
    input logic              lk_hit
);
    // R3
    hit_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && lk_hit) |=> (host_rvalid && !fetch_req && !miss_pulse));

    // R5
    miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !lk_hit) |=> (fetch_req && miss_pulse));

    // R5
    miss_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> !miss_pulse);

    // R5
    miss_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> (ring_cur == ring_next));

    // R6
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fill_valid && fill_last) |=> host_rvalid);

    // R7
    next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ring_next) && !miss_pulse) |->
            (ring_next == SLOT_W'((int'($past(ring_next)) + 1) % SLOTS)));

    // R8
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ring_next) && !miss_pulse) |-> (ring_next != ring_cur));

    // R10
    tgt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> !tgt_valid);

    // R11
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ready && (host_rvalid || fetch_req)));
endmodule

bind norfe_read_front norfe_read_front_chk #(
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .fetch_req   (fetch_req),
    .fill_valid  (fill_valid),
    .fill_last   (fill_last),
    .miss_pulse  (miss_pulse),
    .tgt_valid   (tgt_valid),
    .ring_cur    (ring_cur),
    .ring_next   (ring_next),
    .lk_hit      (lk_hit)
);

// File: tb/sim_norfe_read_front.sv
module sim_norfe_read_front;
    localparam int ADDR_W    = 12;
    localparam int LBA_BYTES = 16;
    localparam int PAGE_LBAS = 2;
    localparam int SLOTS     = 4;
    localparam int PB        = LBA_BYTES * PAGE_LBAS;
    localparam int PAGE_W    = ADDR_W - $clog2(PB);
    localparam int LBA_W     = ADDR_W - $clog2(LBA_BYTES);
    localparam int SLOT_W    = $clog2(SLOTS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_valid = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic host_ready, host_rvalid, fetch_req, miss_pulse, tgt_valid;
    logic [7:0] host_rdata;
    logic [LBA_W-1:0] fetch_lba, tgt_lba;
    logic fill_valid = 1'b0, fill_last = 1'b0, fill_branch = 1'b0;
    logic [7:0] fill_data = '0;
    logic [PAGE_W-1:0] fill_tag = '0;
    logic [SLOT_W-1:0] ring_cur, ring_next;

    always #10 clk = ~clk;

    norfe_read_front #(
        .ADDR_W (ADDR_W), .LBA_BYTES (LBA_BYTES), .PAGE_LBAS (PAGE_LBAS), .SLOTS (SLOTS)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .host_valid (host_valid), .host_addr (host_addr), .host_ready (host_ready),
        .host_rvalid (host_rvalid), .host_rdata (host_rdata),
        .fetch_req (fetch_req), .fetch_lba (fetch_lba),
        .fill_valid (fill_valid), .fill_data (fill_data), .fill_last (fill_last),
        .fill_tag (fill_tag), .fill_branch (fill_branch),
        .ring_cur (ring_cur), .ring_next (ring_next),
        .miss_pulse (miss_pulse), .tgt_valid (tgt_valid), .tgt_lba (tgt_lba)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench view of the ring
    int mcur = 0, mnxt = 0;
    bit mval [SLOTS];
    bit mbr  [SLOTS];
    int mtag [SLOTS];

    function automatic logic [7:0] page_byte(input int tag, input int off);
        return 8'(((tag * 13) + (off * 7) + 8'h3C) ^ (tag >> 2));
    endfunction

    function automatic int rinc(input int s);
        return (s + 1) % SLOTS;
    endfunction

    function automatic bit mfull();
        return rinc(mnxt) == mcur;
    endfunction

    function automatic int mfind(input int tag);
        int span;
        span = (mnxt - mcur + SLOTS) % SLOTS;
        for (int i = 0; i <= span; i++) begin
            if (mval[(mcur + i) % SLOTS] && mtag[(mcur + i) % SLOTS] == tag)
                return (mcur + i) % SLOTS;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_page(input int tag, input bit br);
        bit was_full;
        int exp_next;
        was_full = mfull();
        exp_next = was_full ? mnxt : rinc(mnxt);
        for (int o = 0; o < PB; o++) begin
            @(negedge clk);
            fill_valid  = 1'b1;
            fill_data   = page_byte(tag, o);
            fill_tag    = PAGE_W'(tag);
            fill_branch = br;
            fill_last   = (o == PB - 1);
        end
        @(negedge clk);
        fill_valid = 1'b0;
        fill_last  = 1'b0;
        if (was_full) begin
            chk(int'(ring_next) == exp_next, "R8", "ring_next after push into full ring", int'(ring_next), exp_next);
        end else begin
            chk(int'(ring_next) == exp_next, "R7", "ring_next after prefetch push", int'(ring_next), exp_next);
            mnxt = exp_next;
            mval[mnxt] = 1'b1;
            mtag[mnxt] = tag;
            mbr[mnxt]  = br;
        end
    endtask

    task automatic do_read(input int tag, input int off, input bit br, input string req);
        int addr, hs, ms;
        bit exp_tgt;
        addr = tag * PB + off;
        hs = mfind(tag);
        exp_tgt = mval[mcur] && mbr[mcur] && (mtag[mcur] != tag);
        @(negedge clk);
        chk(host_ready == 1'b1, "R11", "host_ready before request", int'(host_ready), 1);
        host_valid = 1'b1;
        host_addr  = ADDR_W'(addr);
        @(negedge clk);
        host_valid = 1'b0;
        chk(tgt_valid == exp_tgt, "R10", "tgt_valid", int'(tgt_valid), int'(exp_tgt));
        if (exp_tgt)
            chk(int'(tgt_lba) == (addr / LBA_BYTES), "R10", "tgt_lba", int'(tgt_lba), addr / LBA_BYTES);
        if (hs >= 0) begin
            chk(host_rvalid && !fetch_req && !miss_pulse, req, "hit reply flags", int'(host_rvalid), 1);
            chk(host_rdata == page_byte(tag, off), req, "hit data", int'(host_rdata), int'(page_byte(tag, off)));
            chk(int'(ring_cur) == hs, req, "ring_cur after hit", int'(ring_cur), hs);
            chk(int'(ring_next) == mnxt, "R3", "ring_next after hit", int'(ring_next), mnxt);
            mcur = hs;
        end else begin
            ms = rinc(mcur);
            chk(fetch_req && miss_pulse && !host_rvalid, req, "miss flags", int'({fetch_req, miss_pulse}), 3);
            chk(int'(fetch_lba) == tag * PAGE_LBAS, "R2", "fetch_lba", int'(fetch_lba), tag * PAGE_LBAS);
            chk(int'(ring_cur) == ms && int'(ring_next) == ms, "R5", "collapsed ring",
                int'(ring_cur) * 16 + int'(ring_next), ms * 17);
            mcur = ms;
            mnxt = ms;
            mval[ms] = 1'b0;
            for (int o = 0; o < PB; o++) begin
                if (o != 0) @(negedge clk);
                if (o == 1)
                    chk(!miss_pulse && fetch_req, "R5", "miss_pulse single cycle", int'(miss_pulse), 0);
                fill_valid  = 1'b1;
                fill_data   = page_byte(tag, o);
                fill_tag    = PAGE_W'(tag);
                fill_branch = br;
                fill_last   = (o == PB - 1);
            end
            @(negedge clk);
            fill_valid = 1'b0;
            fill_last  = 1'b0;
            chk(host_rvalid == 1'b1, "R6", "rvalid after last beat", int'(host_rvalid), 1);
            chk(host_rdata == page_byte(tag, off), "R6", "miss data", int'(host_rdata), int'(page_byte(tag, off)));
            mval[ms] = 1'b1;
            mtag[ms] = tag;
            mbr[ms]  = br;
        end
        @(negedge clk);
        chk(!host_rvalid && host_ready, "R11", "single reply cycle", int'(host_rvalid), 0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        for (int i = 0; i < SLOTS; i++) begin
            mval[i] = 1'b0; mbr[i] = 1'b0; mtag[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready && !host_rvalid && !fetch_req && !miss_pulse && !tgt_valid,
            "R1", "reset outputs", int'(host_ready), 1);
        chk(ring_cur == 0 && ring_next == 0, "R1", "reset indices", int'(ring_cur) + int'(ring_next), 0);

        do_read(5, 3, 1'b0, "R5");          // cold miss, ring -> slot 1
        do_read(5, 30, 1'b0, "R3");         // same page, second LBA
        push_page(6, 1'b1);                 // slot 2
        push_page(7, 1'b0);                 // slot 3
        push_page(8, 1'b0);                 // slot 0, ring full
        push_page(9, 1'b0);                 // refused
        do_read(5, 0, 1'b0, "R8");          // current page intact
        do_read(7, 9, 1'b0, "R7");          // skip forward, slot 3
        do_read(6, 4, 1'b1, "R4");          // slot 2 is behind current: miss
        push_page(4, 1'b0);
        push_page(4, 1'b0);
        do_read(4, 20, 1'b0, "R9");         // nearest copy, target pulse from branch page
        do_read(4, 2, 1'b0, "R3");          // same page, no pulse

        for (int it = 0; it < 220; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0) begin
                push_page(int'($urandom % 10), 1'(($urandom % 2)));
            end else begin
                int t;
                t = int'($urandom % 10);
                do_read(t, int'($urandom % PB), 1'(($urandom % 2)), (mfind(t) >= 0) ? "R3" : "R5");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule